// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one elementary NAND flash bus operation each time software writes a trigger code into its operation register. It can latch a command byte, latch an address byte, push a section of its internal page buffer out to the flash (program data), pull a section in from the flash (page read), fetch the device identification bytes, or fetch the device status byte. The flash side is a simplified 8-bit bus with a command latch strobe, an address latch strobe, active-low write and read strobes and an active-low ready/busy input.

The internal buffer holds `NUM_SECT` main sections of `SECT_BYTES` bytes each, followed by a spare area holding `SPARE_BYTES` bytes per section. Software fills or reads this buffer through a byte port, picks the section with a select register, optionally includes the spare bytes, and fires the operation. On completion a sticky done flag is set and a maskable interrupt goes high. Software clears the flag by writing the operation register with bit 15 low.

Top module: `nand_op_sequencer`

## Requirements
- R1: After reset every register reads 0, `irq` is low, both strobes (`nand_we_n`, `nand_re_n`) are high, `nand_cle`, `nand_ale` and `nand_io_oe` are low. Register offsets: 0 operation, 1 configuration, 2 command byte, 3 address byte, 4 section select.
- R2: Writing 0x0001 to offset 0 drives the byte held at offset 2 with `nand_cle` high before, during and after exactly one `nand_we_n` low pulse lasting `WE_LOW` clocks, `nand_ale` low.
- R3: Writing 0x0002 to offset 0 drives the byte held at offset 3 in the same way with `nand_ale` high and `nand_cle` low.
- R4: Writing 0x0004 to offset 0 sends the `SECT_BYTES` bytes of the selected main section (buffer byte address sel*SECT_BYTES + i) in ascending order, one `nand_we_n` pulse each with both latch strobes low; when configuration bit 2 is set it then sends that section's spare bytes (address NUM_SECT*SECT_BYTES + sel*SPARE_BYTES + j).
- R5: Writing 0x0008 to offset 0 issues one `nand_re_n` pulse per byte and stores the bytes read into the selected main section in order, followed by its spare bytes when configuration bit 2 is set.
- R6: Writing 0x0010 to offset 0 reads `ID_BYTES` bytes into main section 0 starting at byte 0, whatever the section select holds.
- R7: Writing 0x0020 to offset 0 reads one byte into byte 0 of the selected main section; byte 1 is left unchanged.
- R8: Bit 15 of offset 0 becomes 1 when an operation ends and stays 1 until a write to offset 0 with bit 15 low; a write with bit 15 high leaves it unchanged.
- R9: `irq` is high exactly while the done flag is set and configuration bit 4 is clear; setting bit 4 keeps `irq` low without stopping the done flag.
- R10: An operation does not complete while `nand_rb_n` is low; it completes after `nand_rb_n` returns high.
- R11: A trigger written while an operation runs is ignored, and a trigger value with other than exactly one of bits 5:0 set starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| buf_we | input | 1 | Buffer byte write strobe |
| buf_addr | input | AW | Buffer byte address |
| buf_wdata | input | 8 | Buffer write byte |
| buf_rdata | output | 8 | Buffer byte at `buf_addr` |
| irq | output | 1 | Completion interrupt |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Flash data bus out |
| nand_io_oe | output | 1 | Flash data bus drive enable |
| nand_io_in | input | 8 | Flash data bus in |
| nand_rb_n | input | 1 | Ready (high) / busy (low) from flash |

## Verification
The bench builds the block with 16-byte sections, 4 spare bytes per section, four sections and 4 identification bytes, keeping the default 2-clock strobe widths. The short sections make a full transfer with and without spare bytes only twenty strobes long, so every section boundary, the jump from main to spare addressing and the placement of identification and status bytes relative to other sections can be checked byte by byte. Holding the ready/busy input low from the bench exposes the completion wait and the window in which a second trigger must be dropped.

// File: rtl/nseq_pkg.sv
`timescale 1ns/1ps
package nseq_pkg;

    typedef enum logic [2:0] {
        OP_NONE, OP_CMD, OP_ADDR, OP_DIN, OP_DOUT, OP_ID, OP_STAT
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_PULSE, ST_RECOV, ST_WAIT
    } state_e;

    localparam logic [2:0] REG_OP   = 3'd0;
    localparam logic [2:0] REG_CFG  = 3'd1;
    localparam logic [2:0] REG_CMD  = 3'd2;
    localparam logic [2:0] REG_ADDR = 3'd3;
    localparam logic [2:0] REG_SEL  = 3'd4;

    localparam int DONE_BIT  = 15;
    localparam int SPARE_BIT = 2;
    localparam int MASK_BIT  = 4;

    function automatic op_e trig_to_op(logic [5:0] t);
        case (t)
            6'h01:   return OP_CMD;
            6'h02:   return OP_ADDR;
            6'h04:   return OP_DIN;
            6'h08:   return OP_DOUT;
            6'h10:   return OP_ID;
            6'h20:   return OP_STAT;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/nseq_buffer.sv
`timescale 1ns/1ps
module nseq_buffer #(
    parameter int DEPTH = 2112,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [7:0]    eng_wdata,
    output logic [7:0]    eng_rdata
);
    logic [7:0] mem [DEPTH];

    // Engine writes take priority over host writes in the same cycle.
    always_ff @(posedge clk) begin
        if (eng_we) begin
            mem[eng_addr] <= eng_wdata;
        end else if (host_we && (int'(host_addr) < DEPTH)) begin
            mem[host_addr] <= host_wdata;
        end
    end

    always_comb begin
        host_rdata = (int'(host_addr) < DEPTH) ? mem[host_addr] : 8'h00;
        eng_rdata  = mem[eng_addr];
    end
endmodule

// File: rtl/nseq_addr_map.sv
`timescale 1ns/1ps
module nseq_addr_map #(
    parameter int SECT_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int NUM_SECT    = 4,
    parameter int AW          = 12,
    localparam int SW = $clog2(NUM_SECT),
    localparam int IW = $clog2(SECT_BYTES + SPARE_BYTES + 1)
) (
    input  logic [SW-1:0] sect,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] MAIN_TOTAL = AW'(NUM_SECT * SECT_BYTES);

    // Main bytes come first; past the section length the index walks the
    // section's slice of the spare area.
    always_comb begin
        if (idx < IW'(SECT_BYTES)) begin
            addr = AW'(sect) * AW'(SECT_BYTES) + AW'(idx);
        end else begin
            addr = MAIN_TOTAL + AW'(sect) * AW'(SPARE_BYTES)
                 + AW'(idx) - AW'(SECT_BYTES);
        end
    end
endmodule

// File: rtl/nseq_regs.sv
`timescale 1ns/1ps
module nseq_regs
    import nseq_pkg::*;
#(
    parameter int NUM_SECT = 4,
    localparam int SW = $clog2(NUM_SECT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic          busy,
    input  logic          done_set,
    output logic          start,
    output op_e           start_op,
    output logic          cfg_spare,
    output logic          irq,
    output logic          done,
    output logic [7:0]    cmd_byte,
    output logic [7:0]    addr_byte,
    output logic [SW-1:0] sel
);
    typedef struct packed {
        logic          done;
        logic [15:0]   cfg;
        logic [7:0]    cmd;
        logic [7:0]    addr;
        logic [SW-1:0] sel;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        start    = 1'b0;
        start_op = trig_to_op(reg_wdata[5:0]);
        if (reg_we) begin
            case (reg_addr)
                REG_OP: begin
                    if (!reg_wdata[DONE_BIT]) r_d.done = 1'b0;
                    if (!busy && start_op != OP_NONE) start = 1'b1;
                end
                REG_CFG:  r_d.cfg  = reg_wdata;
                REG_CMD:  r_d.cmd  = reg_wdata[7:0];
                REG_ADDR: r_d.addr = reg_wdata[7:0];
                REG_SEL:  r_d.sel  = reg_wdata[SW-1:0];
                default: ;
            endcase
        end
        if (done_set) r_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_addr)
            REG_OP:   reg_rdata = {r_q.done, 15'h0000};
            REG_CFG:  reg_rdata = r_q.cfg;
            REG_CMD:  reg_rdata = {8'h00, r_q.cmd};
            REG_ADDR: reg_rdata = {8'h00, r_q.addr};
            REG_SEL:  reg_rdata = {{(16-SW){1'b0}}, r_q.sel};
            default:  reg_rdata = 16'h0000;
        endcase
    end

    assign cfg_spare = r_q.cfg[SPARE_BIT];
    assign irq       = r_q.done & ~r_q.cfg[MASK_BIT];
    assign done      = r_q.done;
    assign cmd_byte  = r_q.cmd;
    assign addr_byte = r_q.addr;
    assign sel       = r_q.sel;
endmodule

// File: rtl/nseq_engine.sv
`timescale 1ns/1ps
module nseq_engine
    import nseq_pkg::*;
#(
    parameter int SECT_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int NUM_SECT    = 4,
    parameter int ID_BYTES    = 5,
    parameter int WE_LOW      = 2,
    parameter int RE_LOW      = 2,
    parameter int RB_GUARD    = 2,
    localparam int SW   = $clog2(NUM_SECT),
    localparam int IW   = $clog2(SECT_BYTES + SPARE_BYTES + 1),
    localparam int PMAX = (WE_LOW > RE_LOW) ? ((WE_LOW > RB_GUARD) ? WE_LOW : RB_GUARD)
                                            : ((RE_LOW > RB_GUARD) ? RE_LOW : RB_GUARD),
    localparam int CW   = $clog2(PMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  op_e           start_op,
    input  logic          cfg_spare,
    input  logic [SW-1:0] sel,
    input  logic [7:0]    cmd_byte,
    input  logic [7:0]    addr_byte,
    input  logic [7:0]    buf_byte,
    output logic [SW-1:0] cur_sect,
    output logic [IW-1:0] cur_idx,
    output logic          buf_we,
    output logic          busy,
    output logic          done_set,
    output op_e           cur_op,
    output logic          nand_cle,
    output logic          nand_ale,
    output logic          nand_we_n,
    output logic          nand_re_n,
    output logic [7:0]    nand_io_out,
    output logic          nand_io_oe,
    input  logic          nand_rb_n
);
    localparam logic [CW-1:0] WE_M1  = CW'(WE_LOW - 1);
    localparam logic [CW-1:0] RE_M1  = CW'(RE_LOW - 1);
    localparam logic [CW-1:0] GUARD  = CW'(RB_GUARD);

    typedef struct packed {
        state_e        st;
        op_e           op;
        logic [SW-1:0] sect;
        logic          spare;
        logic [IW-1:0] idx;
        logic [CW-1:0] cnt;
        logic          rb_s1;
        logic          rb_s2;
    } eng_t;

    eng_t e_d, e_q;
    logic          is_read;
    logic [IW-1:0] nbytes;
    logic [CW-1:0] pw_m1;

    always_comb begin
        is_read = (e_q.op == OP_DOUT) || (e_q.op == OP_ID) || (e_q.op == OP_STAT);
        pw_m1   = is_read ? RE_M1 : WE_M1;
        case (e_q.op)
            OP_DIN, OP_DOUT: nbytes = IW'(SECT_BYTES) + (e_q.spare ? IW'(SPARE_BYTES) : '0);
            OP_ID:           nbytes = IW'(ID_BYTES);
            default:         nbytes = IW'(1);
        endcase
    end

    always_comb begin
        e_d       = e_q;
        e_d.rb_s1 = nand_rb_n;
        e_d.rb_s2 = e_q.rb_s1;
        done_set  = 1'b0;
        buf_we    = 1'b0;
        case (e_q.st)
            ST_IDLE: begin
                if (start) begin
                    e_d.op    = start_op;
                    e_d.sect  = (start_op == OP_ID) ? '0 : sel;
                    e_d.spare = cfg_spare;
                    e_d.idx   = '0;
                    e_d.cnt   = '0;
                    e_d.st    = ST_SETUP;
                end
            end
            ST_SETUP: begin
                e_d.cnt = '0;
                e_d.st  = ST_PULSE;
            end
            ST_PULSE: begin
                if (e_q.cnt == pw_m1) begin
                    buf_we  = is_read;
                    e_d.cnt = '0;
                    e_d.st  = ST_RECOV;
                end else begin
                    e_d.cnt = e_q.cnt + 1'b1;
                end
            end
            ST_RECOV: begin
                if (e_q.idx == nbytes - 1'b1) begin
                    e_d.cnt = '0;
                    e_d.st  = ST_WAIT;
                end else begin
                    e_d.idx = e_q.idx + 1'b1;
                    e_d.st  = ST_PULSE;
                end
            end
            ST_WAIT: begin
                if (e_q.cnt < GUARD) begin
                    e_d.cnt = e_q.cnt + 1'b1;
                end else if (e_q.rb_s2) begin
                    done_set = 1'b1;
                    e_d.op   = OP_NONE;
                    e_d.st   = ST_IDLE;
                end
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{st: ST_IDLE, op: OP_NONE, rb_s1: 1'b1, rb_s2: 1'b1, default: '0};
        else        e_q <= e_d;
    end

    logic on_bus;
    assign on_bus      = (e_q.st == ST_SETUP) || (e_q.st == ST_PULSE) || (e_q.st == ST_RECOV);
    assign busy        = (e_q.st != ST_IDLE);
    assign cur_op      = e_q.op;
    assign cur_sect    = e_q.sect;
    assign cur_idx     = e_q.idx;
    assign nand_cle    = on_bus && (e_q.op == OP_CMD);
    assign nand_ale    = on_bus && (e_q.op == OP_ADDR);
    assign nand_we_n   = !((e_q.st == ST_PULSE) && !is_read);
    assign nand_re_n   = !((e_q.st == ST_PULSE) && is_read);
    assign nand_io_oe  = on_bus && !is_read;
    assign nand_io_out = (e_q.op == OP_CMD)  ? cmd_byte  :
                         (e_q.op == OP_ADDR) ? addr_byte : buf_byte;
endmodule

// File: rtl/nand_op_sequencer.sv
`timescale 1ns/1ps
module nand_op_sequencer
    import nseq_pkg::*;
#(
    parameter int SECT_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int NUM_SECT    = 4,
    parameter int ID_BYTES    = 5,
    parameter int WE_LOW      = 2,
    parameter int RE_LOW      = 2,
    parameter int RB_GUARD    = 2,
    localparam int DEPTH = NUM_SECT * (SECT_BYTES + SPARE_BYTES),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic          buf_we,
    input  logic [AW-1:0] buf_addr,
    input  logic [7:0]    buf_wdata,
    output logic [7:0]    buf_rdata,
    output logic          irq,
    output logic          nand_cle,
    output logic          nand_ale,
    output logic          nand_we_n,
    output logic          nand_re_n,
    output logic [7:0]    nand_io_out,
    output logic          nand_io_oe,
    input  logic [7:0]    nand_io_in,
    input  logic          nand_rb_n
);
    localparam int SW = $clog2(NUM_SECT);
    localparam int IW = $clog2(SECT_BYTES + SPARE_BYTES + 1);

    logic          start_w, cfg_spare_w, busy_w, done_set_w, done_w, eng_we_w;
    op_e           start_op_w, cur_op_w;
    logic [7:0]    cmd_w, addr_w, eng_rdata_w;
    logic [SW-1:0] sel_w, sect_w;
    logic [IW-1:0] idx_w;
    logic [AW-1:0] eng_addr_w;

    nseq_regs #(.NUM_SECT(NUM_SECT)) i_regs (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .busy(busy_w), .done_set(done_set_w), .start(start_w), .start_op(start_op_w),
        .cfg_spare(cfg_spare_w), .irq, .done(done_w), .cmd_byte(cmd_w),
        .addr_byte(addr_w), .sel(sel_w)
    );

    nseq_engine #(
        .SECT_BYTES(SECT_BYTES), .SPARE_BYTES(SPARE_BYTES), .NUM_SECT(NUM_SECT),
        .ID_BYTES(ID_BYTES), .WE_LOW(WE_LOW), .RE_LOW(RE_LOW), .RB_GUARD(RB_GUARD)
    ) i_engine (
        .clk, .rst_n, .start(start_w), .start_op(start_op_w), .cfg_spare(cfg_spare_w),
        .sel(sel_w), .cmd_byte(cmd_w), .addr_byte(addr_w), .buf_byte(eng_rdata_w),
        .cur_sect(sect_w), .cur_idx(idx_w), .buf_we(eng_we_w), .busy(busy_w),
        .done_set(done_set_w), .cur_op(cur_op_w), .nand_cle, .nand_ale, .nand_we_n,
        .nand_re_n, .nand_io_out, .nand_io_oe, .nand_rb_n
    );

    nseq_addr_map #(
        .SECT_BYTES(SECT_BYTES), .SPARE_BYTES(SPARE_BYTES), .NUM_SECT(NUM_SECT), .AW(AW)
    ) i_map (
        .sect(sect_w), .idx(idx_w), .addr(eng_addr_w)
    );

    nseq_buffer #(.DEPTH(DEPTH), .AW(AW)) i_buf (
        .clk, .host_we(buf_we), .host_addr(buf_addr), .host_wdata(buf_wdata),
        .host_rdata(buf_rdata), .eng_we(eng_we_w), .eng_addr(eng_addr_w),
        .eng_wdata(nand_io_in), .eng_rdata(eng_rdata_w)
    );
endmodule

// File: rtl/nseq_checker.sv
`timescale 1ns/1ps
module nseq_checker
    import nseq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        done_set,
    input op_e         cur_op,
    input logic        irq,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        nand_cle,
    input logic        nand_ale,
    input logic        nand_we_n,
    input logic        nand_re_n,
    input logic        nand_io_oe,
    input logic        nand_rb_n
);
    AST_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe)); // R1
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R3
    AST_CLE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        nand_cle |-> nand_io_oe); // R2
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |=> !nand_we_n); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n)); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(reg_we && reg_addr == REG_OP && !reg_wdata[DONE_BIT])) |=> done); // R8
    AST_IRQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done); // R9
    AST_READY_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(nand_rb_n, 3)); // R10
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_set && reg_we && reg_addr == REG_OP) |=> $stable(cur_op)); // R11
endmodule

bind nand_op_sequencer nseq_checker i_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .done(done_w), .done_set(done_set_w),
    .cur_op(cur_op_w), .irq(irq), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_oe(nand_io_oe),
    .nand_rb_n(nand_rb_n)
);

// File: tb/test_nand_op_sequencer.sv
`timescale 1ns/1ps
module test_nand_op_sequencer;
    localparam int SECT  = 16;
    localparam int SPARE = 4;
    localparam int NSECT = 4;
    localparam int IDN   = 4;
    localparam int AW    = $clog2(NSECT * (SECT + SPARE));
    localparam int SPARE_BASE = NSECT * SECT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          buf_we = 1'b0;
    logic [AW-1:0] buf_addr = '0;
    logic [7:0]    buf_wdata = '0;
    logic [7:0]    buf_rdata;
    logic          irq, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]    nand_io_out, nand_io_in;
    logic          nand_rb_n = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    nand_op_sequencer #(
        .SECT_BYTES(SECT), .SPARE_BYTES(SPARE), .NUM_SECT(NSECT), .ID_BYTES(IDN)
    ) i_nand_op_sequencer (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .buf_we, .buf_addr,
        .buf_wdata, .buf_rdata, .irq, .nand_cle, .nand_ale, .nand_we_n, .nand_re_n,
        .nand_io_out, .nand_io_oe, .nand_io_in, .nand_rb_n
    );

    // Behavioural flash stub: logs written bytes, serves a read pattern.
    logic [7:0] log_byte [64];
    logic [1:0] log_kind [64];
    int  log_n = 0;
    int  we_width = 0;
    time t_fall = 0;
    logic [7:0] rd_base = 8'h00;
    int  rd_ptr = 0;

    assign nand_io_in = rd_base + 8'(rd_ptr * 7);

    always @(negedge nand_we_n) t_fall = $time;
    always @(posedge nand_we_n) begin
        if (log_n < 64) begin
            log_byte[log_n] = nand_io_out;
            log_kind[log_n] = nand_cle ? 2'd1 : (nand_ale ? 2'd2 : 2'd0);
        end
        log_n++;
        we_width = int'(($time - t_fall) / 20);
    end
    always @(posedge nand_re_n) rd_ptr++;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic buf_wr(int a, logic [7:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = AW'(a); buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic buf_rd(int a, output logic [7:0] d);
        @(negedge clk);
        buf_addr = AW'(a);
        #1 d = buf_rdata;
    endtask

    task automatic wait_done(string req);
        logic seen = 1'b0;
        for (int k = 0; k < 400 && !seen; k++) begin
            @(negedge clk);
            reg_addr = 3'd0;
            #1 seen = reg_rdata[15];
        end
        chk(req, "done flag after operation", int'(seen), 1);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int a = 0; a < 5; a++) begin
            reg_rd(3'(a), v);
            chk("R1", "register reset value", int'(v), 0);
        end
        chk("R1", "irq after reset", int'(irq), 0);
        chk("R1", "idle pins {we_n,re_n,cle,ale,oe}",
            int'({nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe}), 'b11000);
    endtask

    task automatic t_command();
        logic [15:0] v;
        log_n = 0;
        reg_wr(3'd2, 16'h0090);
        reg_wr(3'd0, 16'h0001);
        wait_done("R8");
        chk("R2", "command write count", log_n, 1);
        chk("R2", "command latch kind", int'(log_kind[0]), 1);
        chk("R2", "command byte", int'(log_byte[0]), 'h90);
        chk("R2", "write strobe low clocks", we_width, 2);
        chk("R9", "irq with mask clear", int'(irq), 1);
        reg_wr(3'd0, 16'h0000);
        reg_rd(3'd0, v);
        chk("R8", "done after clearing write", int'(v[15]), 0);
        chk("R9", "irq after clear", int'(irq), 0);
    endtask

    task automatic t_address();
        logic [15:0] v;
        log_n = 0;
        reg_wr(3'd3, 16'h005A);
        reg_wr(3'd0, 16'h0002);
        wait_done("R3");
        chk("R3", "address write count", log_n, 1);
        chk("R3", "address latch kind", int'(log_kind[0]), 2);
        chk("R3", "address byte", int'(log_byte[0]), 'h5A);
        reg_wr(3'd0, 16'h8000);
        reg_rd(3'd0, v);
        chk("R8", "done kept by write of bit15 high", int'(v[15]), 1);
        reg_wr(3'd0, 16'h0000);
    endtask

    task automatic t_data_in();
        int bad;
        for (int i = 0; i < SECT; i++) buf_wr(2 * SECT + i, 8'hA0 + 8'(i));
        for (int j = 0; j < SPARE; j++) buf_wr(SPARE_BASE + 2 * SPARE + j, 8'h50 + 8'(j));
        reg_wr(3'd4, 16'd2);
        reg_wr(3'd1, 16'h0000);
        log_n = 0;
        reg_wr(3'd0, 16'h0004);
        wait_done("R4");
        chk("R4", "program byte count main only", log_n, SECT);
        bad = 0;
        for (int i = 0; i < SECT; i++)
            if (log_byte[i] != 8'hA0 + 8'(i) || log_kind[i] != 2'd0) bad++;
        chk("R4", "main bytes mismatching", bad, 0);
        reg_wr(3'd0, 16'h0000);
        reg_wr(3'd1, 16'h0004);
        log_n = 0;
        reg_wr(3'd0, 16'h0004);
        wait_done("R4");
        chk("R4", "program byte count with spare", log_n, SECT + SPARE);
        bad = 0;
        for (int i = 0; i < SECT; i++) if (log_byte[i] != 8'hA0 + 8'(i)) bad++;
        for (int j = 0; j < SPARE; j++) if (log_byte[SECT + j] != 8'h50 + 8'(j)) bad++;
        chk("R4", "main+spare bytes mismatching", bad, 0);
        reg_wr(3'd0, 16'h0000);
    endtask

    task automatic t_data_out();
        int bad;
        logic [7:0] b;
        reg_wr(3'd4, 16'd1);
        reg_wr(3'd1, 16'h0004);
        rd_base = 8'h30; rd_ptr = 0;
        reg_wr(3'd0, 16'h0008);
        wait_done("R5");
        chk("R5", "read strobe count", rd_ptr, SECT + SPARE);
        bad = 0;
        for (int i = 0; i < SECT; i++) begin
            buf_rd(SECT + i, b);
            if (b != 8'h30 + 8'(i * 7)) bad++;
        end
        for (int j = 0; j < SPARE; j++) begin
            buf_rd(SPARE_BASE + SPARE + j, b);
            if (b != 8'h30 + 8'((SECT + j) * 7)) bad++;
        end
        chk("R5", "stored bytes mismatching", bad, 0);
        reg_wr(3'd0, 16'h0000);
        reg_wr(3'd1, 16'h0000);
    endtask

    task automatic t_read_id();
        int bad;
        logic [7:0] b;
        buf_wr(3 * SECT, 8'h11);
        reg_wr(3'd4, 16'd3);
        rd_base = 8'hEC; rd_ptr = 0;
        reg_wr(3'd0, 16'h0010);
        wait_done("R6");
        bad = 0;
        for (int i = 0; i < IDN; i++) begin
            buf_rd(i, b);
            if (b != 8'hEC + 8'(i * 7)) bad++;
        end
        chk("R6", "id bytes mismatching in section 0", bad, 0);
        buf_rd(3 * SECT, b);
        chk("R6", "selected section untouched", int'(b), 'h11);
        reg_wr(3'd0, 16'h0000);
    endtask

    task automatic t_status();
        logic [7:0] b;
        buf_wr(2 * SECT, 8'h22);
        buf_wr(2 * SECT + 1, 8'h33);
        reg_wr(3'd4, 16'd2);
        rd_base = 8'hE0; rd_ptr = 0;
        reg_wr(3'd0, 16'h0020);
        wait_done("R7");
        chk("R7", "status read strobes", rd_ptr, 1);
        buf_rd(2 * SECT, b);
        chk("R7", "status byte 0", int'(b), 'hE0);
        buf_rd(2 * SECT + 1, b);
        chk("R7", "byte 1 unchanged", int'(b), 'h33);
        reg_wr(3'd0, 16'h0000);
    endtask

    task automatic t_mask();
        reg_wr(3'd1, 16'h0010);
        reg_wr(3'd0, 16'h0001);
        wait_done("R9");
        chk("R9", "irq while masked", int'(irq), 0);
        reg_wr(3'd1, 16'h0000);
        #1 chk("R9", "irq after unmask", int'(irq), 1);
        reg_wr(3'd0, 16'h0000);
    endtask

    task automatic t_busy();
        logic [15:0] v;
        @(negedge clk) nand_rb_n = 1'b0;
        reg_wr(3'd0, 16'h0001);
        repeat (60) @(negedge clk);
        reg_rd(3'd0, v);
        chk("R10", "done while busy held", int'(v[15]), 0);
        @(negedge clk) nand_rb_n = 1'b1;
        wait_done("R10");
        reg_wr(3'd0, 16'h0000);
    endtask

    task automatic t_ignore();
        logic [15:0] v;
        log_n = 0;
        @(negedge clk) nand_rb_n = 1'b0;
        reg_wr(3'd2, 16'h0070);
        reg_wr(3'd0, 16'h0001);
        repeat (10) @(negedge clk);
        reg_wr(3'd3, 16'h0033);
        reg_wr(3'd0, 16'h0002);
        repeat (10) @(negedge clk);
        nand_rb_n = 1'b1;
        wait_done("R11");
        repeat (20) @(negedge clk);
        chk("R11", "bus writes after trigger during busy", log_n, 1);
        chk("R11", "only the command was latched", int'(log_kind[0]), 1);
        reg_wr(3'd0, 16'h0000);
        log_n = 0;
        reg_wr(3'd0, 16'h0003);
        repeat (40) @(negedge clk);
        reg_rd(3'd0, v);
        chk("R11", "bus writes after two-bit trigger", log_n, 0);
        chk("R11", "done after two-bit trigger", int'(v[15]), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        log_n = 0; rd_ptr = 0;
        t_reset();
        t_command();
        t_address();
        t_data_in();
        t_data_out();
        t_read_id();
        t_status();
        t_mask();
        t_busy();
        t_ignore();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule